// File: doc/BRIEF.md
# Tile Elementwise Rectifier

This engine applies max(x, 0) to every element of the valid sub-rectangle of a two-dimensional tile. The tile sits row-major in a local vector buffer, and the results go to the same positions in a destination buffer. Software issues one command that carries the element type, the source and destination base word addresses, the allocated row and column counts and the valid row and column counts. The engine then walks the valid region one buffer word per cycle. It reads through a synchronous RAM read port with one cycle of latency, rectifies the word and writes it through a RAM write port that has a mask for each 16-bit half.

Three element types are supported: signed 32-bit integer, single precision float and half precision float. Half elements are packed two to a 32-bit word, so each half is rectified on its own and masked on its own. A command whose valid counts exceed the allocated counts is refused, and so is a command with an unknown type or a half tile with an odd column count. A refused command raises the error flag and touches no memory. The source and destination are taken to share their valid dimensions. The engine does not check this.

The buffer ports are plain RAM ports with no back-pressure. A read is issued only when the engine wants the data, and a write is always accepted. The command side is a plain start/busy/done handshake.

Top module: `tile_relu_engine`

## Requirements
- R1: With type code 0 (signed 32-bit integer), a word whose bit 31 is set is written as 0, and any other word is written unchanged.
- R2: With type code 1 (single float), a word with bit 31 set that is not a NaN (a NaN has bits 30:23 all ones and a nonzero fraction) is written as 32'h0000_0000, which turns -0 into +0. A NaN of either sign, and every positive value, passes unchanged.
- R3: With type code 2 (half float), bits 15:0 hold the even element and bits 31:16 the odd element of a pair. Each half follows the rule of R2 at 16 bits: the sign is bit 15, a NaN has exponent bits 14:10 all ones and a nonzero fraction, and the zero result is 16'h0000.
- R4: Element (i, j) lives at element offset i*cols + j from the base. For 32-bit types that offset is the word offset. For half it is word offset (i*cols + j)/2, with the half chosen by bit 0 of the element offset.
- R5: Only words that hold valid elements are read or written. A half word whose odd element lies outside the valid columns is written with mask 2'b01: dst_wr_half bit 0 enables bits 15:0 and bit 1 enables bits 31:16. Every other word is written with mask 2'b11.
- R6: A command is refused when vrows > rows, vcols > cols, the type code is 3, or the type is half and cols is odd. In that case error and done both pulse in the cycle after start, and no read or write happens.
- R7: A command with vrows = 0 or vcols = 0 that is not refused gives done in the cycle after start, with no error and no memory access.
- R8: A start seen while busy is high is ignored. The running pass finishes with its own descriptor.
- R9: A pass of N words makes exactly N reads on N consecutive cycles, starting the cycle after start. Each write follows its read by two cycles, and done is high N+3 cycles after the start cycle.
- R10: Reads walk the columns of a row before moving to the next row, so within each row the addresses go up by one.
- R11: done is a one-cycle pulse, and busy is low in the cycle done is high.
- R12: After reset, busy, done, error, src_rd_en and dst_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| cmd_type | input | 2 | 0 int32, 1 fp32, 2 fp16, 3 illegal |
| cmd_src_base | input | AW | Source base word address |
| cmd_dst_base | input | AW | Destination base word address |
| cmd_rows | input | DW | Allocated rows |
| cmd_cols | input | DW | Allocated columns, in elements |
| cmd_vrows | input | DW | Valid rows |
| cmd_vcols | input | DW | Valid columns, in elements |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Command refused, pulses with done |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | AW | Source read word address |
| src_rd_data | input | 32 | Source word, the cycle after the request |
| dst_wr_en | output | 1 | Destination write |
| dst_wr_addr | output | AW | Destination word address |
| dst_wr_data | output | 32 | Rectified word |
| dst_wr_half | output | 2 | Half-word write enables |

## Verification
The bench goes after the float edge values: negative zero, NaN with either sign, and negative numbers in both halves of a packed word. A design that tests only the sign would zero out negative NaNs, and one that sets the fp16 lanes wrongly would clobber or swap elements. It runs half tiles with an odd valid column count, where a missing mask would overwrite the padding element next door. It also runs zero-size and refused commands, where a careless design would still issue a stray access. Finally it sends a start in the middle of a pass, which a design that re-latches the descriptor would follow, and it checks the cycle of done, because an off-by-one in the walker or pipeline shows up there.

// File: rtl/tre_pkg.sv
package tre_pkg;

  typedef enum logic [1:0] {
    TY_INT32 = 2'd0,
    TY_FP32  = 2'd1,
    TY_FP16  = 2'd2,
    TY_BAD   = 2'd3
  } elem_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } eng_state_e;

  function automatic logic [31:0] rect_int32(input logic [31:0] x);
    return x[31] ? 32'd0 : x;
  endfunction

  function automatic logic [31:0] rect_fp32(input logic [31:0] x);
    logic nan;
    nan = (&x[30:23]) && (|x[22:0]);
    return (x[31] && !nan) ? 32'd0 : x;
  endfunction

  function automatic logic [15:0] rect_fp16(input logic [15:0] x);
    logic nan;
    nan = (&x[14:10]) && (|x[9:0]);
    return (x[15] && !nan) ? 16'd0 : x;
  endfunction

endpackage

// File: rtl/tre_rectify.sv
module tre_rectify
  import tre_pkg::*;
(
  input  elem_type_e  kind,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  localparam int LANES = 2;
  localparam int LW    = 32 / LANES;

  logic [31:0] half_res;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign half_res[k*LW +: LW] = rect_fp16(din[k*LW +: LW]);
    end
  endgenerate

  always_comb begin
    unique case (kind)
      TY_INT32: dout = rect_int32(din);
      TY_FP32:  dout = rect_fp32(din);
      TY_FP16:  dout = half_res;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/tre_walker.sv
module tre_walker #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          half,
  input  logic [DW-1:0] cols,
  input  logic [DW-1:0] vrows,
  input  logic [DW-1:0] vcols,
  output logic [AW-1:0] off,
  output logic [1:0]    mask,
  output logic          last
);
  logic [DW-1:0] row_q, wcol_q;
  logic [AW-1:0] row_off_q;
  logic [DW:0]   wc_ext;
  logic [DW-1:0] word_cols;
  logic [AW-1:0] stride;
  logic          last_col, last_row;

  assign wc_ext    = half ? (({1'b0, vcols} + 1'b1) >> 1) : {1'b0, vcols};
  assign word_cols = wc_ext[DW-1:0];
  assign stride    = half ? AW'(cols >> 1) : AW'(cols);
  assign last_col  = (wcol_q == word_cols - 1'b1);
  assign last_row  = (row_q == vrows - 1'b1);
  assign last      = last_col && last_row;
  assign off       = row_off_q + AW'(wcol_q);
  assign mask      = (half && last_col && vcols[0]) ? 2'b01 : 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row_q     <= '0;
      wcol_q    <= '0;
      row_off_q <= '0;
    end else if (step) begin
      if (last_col) begin
        wcol_q    <= '0;
        row_q     <= row_q + 1'b1;
        row_off_q <= row_off_q + stride;
      end else begin
        wcol_q <= wcol_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tile_relu_engine.sv
module tile_relu_engine
  import tre_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cmd_type,
  input  logic [AW-1:0] cmd_src_base,
  input  logic [AW-1:0] cmd_dst_base,
  input  logic [DW-1:0] cmd_rows,
  input  logic [DW-1:0] cmd_cols,
  input  logic [DW-1:0] cmd_vrows,
  input  logic [DW-1:0] cmd_vcols,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          src_rd_en,
  output logic [AW-1:0] src_rd_addr,
  input  logic [31:0]   src_rd_data,
  output logic          dst_wr_en,
  output logic [AW-1:0] dst_wr_addr,
  output logic [31:0]   dst_wr_data,
  output logic [1:0]    dst_wr_half
);
  eng_state_e    state_q;
  elem_type_e    typ_q;
  logic [AW-1:0] src_base_q, dst_base_q;
  logic [DW-1:0] cols_q, vrows_q, vcols_q;
  logic          done_q, err_q;

  logic          accept, refuse, empty;
  logic [AW-1:0] w_off;
  logic [1:0]    w_mask;
  logic          w_last;

  logic          s1_vld, s1_last;
  logic [AW-1:0] s1_off;
  logic [1:0]    s1_mask;
  logic          s2_last;
  logic [31:0]   rect_word;

  assign accept = start && (state_q == ST_IDLE);
  assign refuse = (cmd_type == TY_BAD) || (cmd_vrows > cmd_rows) ||
                  (cmd_vcols > cmd_cols) ||
                  ((cmd_type == TY_FP16) && cmd_cols[0]);
  assign empty  = (cmd_vrows == '0) || (cmd_vcols == '0);

  tre_walker #(.AW(AW), .DW(DW)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (state_q == ST_RUN),
    .half  (typ_q == TY_FP16),
    .cols  (cols_q),
    .vrows (vrows_q),
    .vcols (vcols_q),
    .off   (w_off),
    .mask  (w_mask),
    .last  (w_last)
  );

  tre_rectify u_rect (
    .kind (typ_q),
    .din  (src_rd_data),
    .dout (rect_word)
  );

  assign src_rd_en   = (state_q == ST_RUN);
  assign src_rd_addr = src_base_q + w_off;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign error       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      typ_q      <= TY_INT32;
      src_base_q <= '0;
      dst_base_q <= '0;
      cols_q     <= '0;
      vrows_q    <= '0;
      vcols_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          typ_q      <= elem_type_e'(cmd_type);
          src_base_q <= cmd_src_base;
          dst_base_q <= cmd_dst_base;
          cols_q     <= cmd_cols;
          vrows_q    <= cmd_vrows;
          vcols_q    <= cmd_vcols;
          if (refuse) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else if (empty) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (w_last) state_q <= ST_DRAIN;
        ST_DRAIN: if (dst_wr_en && s2_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld      <= 1'b0;
      s1_last     <= 1'b0;
      s1_off      <= '0;
      s1_mask     <= '0;
      dst_wr_en   <= 1'b0;
      dst_wr_addr <= '0;
      dst_wr_data <= '0;
      dst_wr_half <= '0;
      s2_last     <= 1'b0;
    end else begin
      s1_vld      <= src_rd_en;
      s1_last     <= src_rd_en && w_last;
      s1_off      <= w_off;
      s1_mask     <= w_mask;
      dst_wr_en   <= s1_vld;
      dst_wr_addr <= dst_base_q + s1_off;
      dst_wr_data <= rect_word;
      dst_wr_half <= s1_mask;
      s2_last     <= s1_vld && s1_last;
    end
  end
endmodule

// File: rtl/tre_checker.sv
module tre_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  typ,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        src_rd_en,
  input logic        dst_wr_en,
  input logic [31:0] dst_wr_data,
  input logic [1:0]  dst_wr_half
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_error_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  assert_read_in_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> busy);
  assert_write_in_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> busy && dst_wr_half != 2'b00);
  assert_write_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> $past(src_rd_en, 2));
  assert_int_nonneg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && typ == 2'd0) |-> !dst_wr_data[31]);
  assert_fp_neg_only_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && typ == 2'd1 && dst_wr_data[31]) |-> (&dst_wr_data[30:23]));
endmodule

bind tile_relu_engine tre_checker u_tre_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .typ         (typ_q),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .src_rd_en   (src_rd_en),
  .dst_wr_en   (dst_wr_en),
  .dst_wr_data (dst_wr_data),
  .dst_wr_half (dst_wr_half)
);

// File: tb/tile_relu_engine_tb_top.sv
module tile_relu_engine_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int MEMW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    cmd_type = '0;
  logic [AW-1:0] cmd_src_base = '0, cmd_dst_base = '0;
  logic [DW-1:0] cmd_rows = '0, cmd_cols = '0, cmd_vrows = '0, cmd_vcols = '0;
  logic          busy, done, error, src_rd_en, dst_wr_en;
  logic [AW-1:0] src_rd_addr, dst_wr_addr;
  logic [31:0]   src_rd_data, dst_wr_data;
  logic [1:0]    dst_wr_half;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] src_mem [MEMW];
  logic [31:0] dst_mem [MEMW];
  logic [31:0] exp_mem [MEMW];
  int          rd_log  [256];

  always #(CLK_NS/2) clk = ~clk;

  tile_relu_engine #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_type(cmd_type),
    .cmd_src_base(cmd_src_base), .cmd_dst_base(cmd_dst_base),
    .cmd_rows(cmd_rows), .cmd_cols(cmd_cols), .cmd_vrows(cmd_vrows),
    .cmd_vcols(cmd_vcols), .busy(busy), .done(done), .error(error),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .dst_wr_half(dst_wr_half)
  );

  always @(posedge clk) begin
    if (src_rd_en) begin
      src_rd_data <= src_mem[src_rd_addr];
      if (rd_cnt < 256) rd_log[rd_cnt] <= int'(src_rd_addr);
      rd_cnt <= rd_cnt + 1;
    end
    if (dst_wr_en) begin
      if (dst_wr_half[0]) dst_mem[dst_wr_addr][15:0]  <= dst_wr_data[15:0];
      if (dst_wr_half[1]) dst_mem[dst_wr_addr][31:16] <= dst_wr_data[31:16];
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref16(input logic [15:0] h);
    if (h[14:10] == 5'h1F && h[9:0] != 10'd0) return h;
    if (h[15]) return 16'h0000;
    return h;
  endfunction

  function automatic logic [31:0] ref32(input int ty, input logic [31:0] x);
    if (ty == 0) return $signed(x) < 0 ? 32'd0 : x;
    if (x[30:23] == 8'hFF && x[22:0] != 23'd0) return x;
    return x[31] ? 32'd0 : x;
  endfunction

  function automatic logic [31:0] pick_word();
    case ($urandom % 8)
      0: return 32'h8000_0000;
      1: return 32'hFFC0_0001;
      2: return 32'h7FC0_0000;
      3: return {16'h8000, 16'hFE01};
      4: return {16'h7E00, 16'h8000};
      default: return $urandom;
    endcase
  endfunction

  task automatic run_cmd(input int ty, input int ar, input int ac, input int vr,
                         input int vc, input int sb, input int db, input bit poke,
                         input string tag);
    bit bad, empty;
    int nw, wc, k;
    for (int i = 0; i < MEMW; i++) begin
      src_mem[i] = pick_word();
      dst_mem[i] = 32'hA5A5_0000 | i;
      exp_mem[i] = 32'hA5A5_0000 | i;
    end
    bad   = (ty == 3) || (vr > ar) || (vc > ac) || (ty == 2 && (ac % 2) == 1);
    empty = (vr == 0) || (vc == 0);
    wc    = (ty == 2) ? (vc + 1) / 2 : vc;
    nw    = (bad || empty) ? 0 : vr * wc;
    if (!bad) begin
      for (int r = 0; r < vr; r++)
        for (int c = 0; c < vc; c++) begin
          int e = r * ac + c;
          if (ty == 2) begin
            logic [31:0] s = src_mem[sb + e / 2];
            if (e % 2 == 0) exp_mem[db + e / 2][15:0]  = ref16(s[15:0]);
            else            exp_mem[db + e / 2][31:16] = ref16(s[31:16]);
          end else begin
            exp_mem[db + e] = ref32(ty, src_mem[sb + e]);
          end
        end
    end
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    cmd_type = 2'(ty); cmd_rows = DW'(ar); cmd_cols = DW'(ac);
    cmd_vrows = DW'(vr); cmd_vcols = DW'(vc);
    cmd_src_base = AW'(sb); cmd_dst_base = AW'(db);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 3000) begin
      if (poke && k == 2) begin
        check(busy == 1'b1, {"R8 busy ", tag}, 32'(busy), 32'd1);
        cmd_type = 2'd0; cmd_vrows = 8'd1; cmd_vcols = 8'd1; cmd_dst_base = '0;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(done == 1'b1, {"R9 watchdog ", tag}, 32'(k), 32'(nw + 3));
    check(k == ((nw == 0) ? 1 : nw + 3), {"R9 done cycle ", tag}, 32'(k),
          32'((nw == 0) ? 1 : nw + 3));
    check(error == bad, {"R6 error flag ", tag}, 32'(error), 32'(bad));
    check(busy == 1'b0, {"R11 busy at done ", tag}, 32'(busy), 32'd0);
    check(rd_cnt == nw && wr_cnt == nw, {"R5 R7 access count ", tag},
          32'(rd_cnt), 32'(nw));
    for (int r = 0; r < vr && nw > 0; r++)
      for (int w = 0; w < wc; w++) begin
        int ea = sb + ((ty == 2) ? (r * ac) / 2 : r * ac) + w;
        int ix = r * wc + w;
        if (ix < 256)
          check(rd_log[ix] == ea, {"R4 R10 read order ", tag}, 32'(rd_log[ix]),
                32'(ea));
      end
    @(negedge clk);
    check(done == 1'b0, {"R11 done pulse ", tag}, 32'(done), 32'd0);
    for (int i = 0; i < MEMW; i++)
      if (dst_mem[i] !== exp_mem[i]) begin
        string rq;
        rq = (ty == 0) ? "R1" : (ty == 1) ? "R2" : "R3";
        check(1'b0, {rq, " R5 R8 dst word ", tag}, dst_mem[i], exp_mem[i]);
      end else begin
        n_chk++;
      end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !src_rd_en && !dst_wr_en, "R12 reset",
          {27'd0, busy, done, error, src_rd_en, dst_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !src_rd_en && !dst_wr_en, "R12 after release",
          {27'd0, busy, done, error, src_rd_en, dst_wr_en}, 32'd0);
    run_cmd(0, 4, 6, 3, 5, 10, 500, 1'b0, "int32");
    run_cmd(1, 5, 7, 5, 7, 0, 600, 1'b0, "fp32 full");
    run_cmd(2, 4, 8, 3, 5, 20, 700, 1'b0, "fp16 odd vcols");
    run_cmd(2, 3, 6, 3, 6, 40, 300, 1'b0, "fp16 even");
    run_cmd(1, 1, 1, 1, 1, 5, 900, 1'b0, "single");
    run_cmd(0, 4, 4, 0, 3, 0, 500, 1'b0, "zero rows R7");
    run_cmd(1, 4, 4, 2, 0, 0, 500, 1'b0, "zero cols R7");
    run_cmd(0, 3, 4, 4, 2, 0, 500, 1'b0, "rows over R6");
    run_cmd(1, 3, 4, 2, 5, 0, 500, 1'b0, "cols over R6");
    run_cmd(3, 3, 4, 2, 2, 0, 500, 1'b0, "type3 R6");
    run_cmd(2, 3, 5, 2, 3, 0, 500, 1'b0, "half odd cols R6");
    run_cmd(1, 4, 6, 4, 6, 0, 500, 1'b1, "start while busy R8");
    for (int t = 0; t < 30; t++) begin
      int ty = $urandom % 3;
      int ar = 1 + $urandom % 8;
      int ac = 1 + $urandom % 12;
      int vr = $urandom % (ar + (($urandom % 6 == 0) ? 2 : 1));
      int vc = $urandom % (ac + 1);
      if (ty == 2 && ($urandom % 4 != 0)) ac = ac + (ac % 2);
      if (vc > ac) vc = ac;
      run_cmd(ty, ar, ac, vr, vc, $urandom % 200, 400 + $urandom % 200,
              ($urandom % 5 == 0), "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule